// File: doc/BRIEF.md
# Word-Oriented March Test Engine

This block is a built-in self-test controller for a synchronous, single-port, word-wide RAM. After a start pulse it issues one memory operation per cycle, stepping through a fixed march algorithm of three elements. Each element has an address direction and a short list of reads and writes. All of an element's operations are applied to one address before the address moves on. Every read word is compared one cycle later with the expected data word.

The whole algorithm is applied once for each standard word background, so that faults between bits inside a word are reached as well as faults in single cells. When the test ends, the engine raises done and reports pass or fail. On a failure it also reports where the first mismatch occurred: the address, the background index and the element index. A stop-on-fail input chooses whether the run halts at the first mismatch or runs to the end.

Top module: `mbist_march_engine`

## Requirements
- R1: Each cycle the engine issues at most one operation, never a read and a write together. Read data is expected on `mem_rdata` in the cycle after `mem_re`, and it is compared there with the expected word of that read.
- R2: The algorithm has three elements, indexed 0, 1 and 2. Element 0 ascends with (w0). Element 1 ascends with (r0, w1). Element 2 descends with (r1, w0, r0). All operations of an element are applied to one address, in the listed order, before the address moves.
- R3: There are log2(DATA_W)+1 backgrounds, indexed from 0. Background 0 is all zeros. In background k>0, bit i is 1 exactly when bit k-1 of i is 0 (for 8 bits: 0x00, 0x55, 0x33, 0x0F). w0 writes the background and w1 writes its complement. r0 expects the background and r1 expects its complement. One full run issues NUM_BG*6*N operations, where N = 2^ADDR_W.
- R4: An ascending element visits addresses 0 to N-1 and a descending element visits N-1 down to 0. The backgrounds are applied in index order 0 upward, each running all elements 0, 1, 2.
- R5: A `start` pulse in idle or done state begins a test. `busy` is high from the next cycle until `done` rises. A `start` while busy is ignored.
- R6: `done` rises two cycles after the last operation is issued, so it is seen NUM_BG*6*N+2 rising edges after the edge that samples `start`, counting that edge. It stays high until the next start. `pass` is high only together with `done`, and only if no mismatch occurred.
- R7: The first mismatch latches its address, background index and element index on `fail_addr`, `fail_bg` and `fail_elem`. Later mismatches do not change them.
- R8: With `stop_on_fail` high, no operation is issued from the cycle in which a mismatch is detected, and `done` follows with `pass` low. With `stop_on_fail` low, the run completes all operations.
- R9: After reset, `busy`, `done`, `pass`, `mem_we` and `mem_re` are low. No operation is issued while not busy.
- R10: A new start clears the failure record, so a clean run after a failing one ends with `pass` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test (pulse) |
| stop_on_fail | input | 1 | Halt at the first mismatch when high |
| mem_rdata | input | DATA_W | Read word from the RAM, one cycle after mem_re |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write word |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | No mismatch seen, valid with done |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_bg | output | BG_W | Background index of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |

## Verification
Two things can fall in the same cycle: the comparison of the previous read, and the issue of the next operation. With stop_on_fail high, a mismatch found in that cycle must suppress the operation that would otherwise be issued. The bench provokes this with a bit stuck at 1 in one word, so the first r0 of element 1 fails. It then requires exactly 27 issued operations (16 writes, five address pairs, the failing read) and pass low. The same fault with stop_on_fail low must still give the full operation count. A stream checker compares every issued operation against a sequence computed in the bench from the algorithm and background formulas.

// File: rtl/mbist_pkg.sv
// Package: shared types and the encoded march algorithm for the test engine.
// Assumes three elements with at most three operations each.
package mbist_pkg;

    localparam int ELEM_W   = 2;
    localparam int OP_W     = 2;
    localparam int NUM_ELEM = 3;

    // One march operation: read or write, and whether the background is inverted
    typedef struct packed {
        logic is_rd;
        logic inv;
    } march_op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    // Address direction of an element: only element 2 descends
    function automatic logic elem_descending(input logic [ELEM_W-1:0] e);
        return (e == 2'd2);
    endfunction

    // Number of operations of an element
    function automatic logic [OP_W-1:0] elem_len(input logic [ELEM_W-1:0] e);
        case (e)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Operation o of element e
    function automatic march_op_t elem_op(input logic [ELEM_W-1:0] e,
                                          input logic [OP_W-1:0]   o);
        march_op_t op;
        op = '{is_rd: 1'b0, inv: 1'b0};
        case (e)
            2'd0: op = '{is_rd: 1'b0, inv: 1'b0};
            2'd1: op = (o == 2'd0) ? '{is_rd: 1'b1, inv: 1'b0}
                                   : '{is_rd: 1'b0, inv: 1'b1};
            default: begin
                case (o)
                    2'd0:    op = '{is_rd: 1'b1, inv: 1'b1};
                    2'd1:    op = '{is_rd: 1'b0, inv: 1'b0};
                    default: op = '{is_rd: 1'b1, inv: 1'b0};
                endcase
            end
        endcase
        return op;
    endfunction

    // Bit bit_pos of background k: zero for k==0, else NOT bit (k-1) of bit_pos
    function automatic logic bg_bit(input int unsigned bit_pos, input int unsigned k);
        if (k == 0) return 1'b0;
        return (((bit_pos >> (k - 1)) & 1) == 0);
    endfunction

endpackage

// File: rtl/mbist_bg_gen.sv
// Background generator: builds the data background word from its index.
// Assumes bg_idx stays below log2(DATA_W)+1; purely combinational.
module mbist_bg_gen #(
    parameter int DATA_W = 8,
    parameter int BG_W   = 2
) (
    input  logic [BG_W-1:0]   bg_idx,
    output logic [DATA_W-1:0] pattern
);
    import mbist_pkg::*;

    // One bit per generate instance, from the bit position and the index
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign pattern[g] = bg_bit(g, 32'(bg_idx));
    end

endmodule

// File: rtl/mbist_seq.sv
// Sequencer: walks backgrounds, elements, addresses and operations in order.
// Issues one operation per cycle in RUN; halt suppresses the current issue
// and ends the test. Assumes N = 2**ADDR_W words.
module mbist_seq #(
    parameter int ADDR_W = 4,
    parameter int NUM_BG = 4,
    parameter int BG_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        halt,
    output logic                        launch,
    output logic                        issue,
    output logic                        op_rd,
    output logic                        op_inv,
    output logic [ADDR_W-1:0]           addr,
    output logic [BG_W-1:0]             bg_idx,
    output logic [mbist_pkg::ELEM_W-1:0] elem_idx,
    output logic                        busy,
    output logic                        done
);
    import mbist_pkg::*;

    localparam logic [BG_W-1:0]   LAST_BG   = BG_W'(NUM_BG - 1);
    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

    seq_state_t        state;
    logic [OP_W-1:0]   op_idx;
    logic [ELEM_W-1:0] elem_nxt;
    logic              desc, last_op, last_addr;
    march_op_t         cur_op;

    // Decode the current operation and the end-of-loop conditions
    always_comb begin
        cur_op    = elem_op(elem_idx, op_idx);
        desc      = elem_descending(elem_idx);
        elem_nxt  = elem_idx + 1'b1;
        last_op   = (op_idx == elem_len(elem_idx) - 2'd1);
        last_addr = desc ? (addr == '0) : (addr == '1);
    end

    assign launch = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign issue  = (state == ST_RUN) && !halt;
    assign op_rd  = cur_op.is_rd;
    assign op_inv = cur_op.inv;
    assign busy   = (state == ST_RUN) || (state == ST_DRAIN);
    assign done   = (state == ST_DONE);

    // State and loop counters: operation, then address, then element, then background
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_idx   <= '0;
            addr     <= '0;
            elem_idx <= '0;
            bg_idx   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        op_idx   <= '0;
                        addr     <= '0;
                        elem_idx <= '0;
                        bg_idx   <= '0;
                    end
                end
                ST_RUN: begin
                    if (halt) begin
                        state <= ST_DONE;
                    end else if (!last_op) begin
                        op_idx <= op_idx + 2'd1;
                    end else begin
                        op_idx <= '0;
                        if (!last_addr) begin
                            addr <= desc ? addr - 1'b1 : addr + 1'b1;
                        end else if (elem_idx != LAST_ELEM) begin
                            elem_idx <= elem_nxt;
                            addr     <= elem_descending(elem_nxt) ? '1 : '0;
                        end else if (bg_idx != LAST_BG) begin
                            bg_idx   <= bg_idx + 1'b1;
                            elem_idx <= '0;
                            addr     <= '0;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/mbist_cmp.sv
// Comparator: aligns the expected word with read data one cycle later,
// flags mismatches and records the first failure. Assumes one-cycle read latency.
module mbist_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int BG_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         rd_issue,
    input  logic [DATA_W-1:0]            exp_word,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [BG_W-1:0]              bg_idx,
    input  logic [mbist_pkg::ELEM_W-1:0] elem_idx,
    input  logic [DATA_W-1:0]            rdata,
    output logic                         mismatch,
    output logic                         fail_seen,
    output logic [ADDR_W-1:0]            fail_addr,
    output logic [BG_W-1:0]              fail_bg,
    output logic [mbist_pkg::ELEM_W-1:0] fail_elem
);
    import mbist_pkg::*;

    logic                rd_q;
    logic [DATA_W-1:0]   exp_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BG_W-1:0]     bg_q;
    logic [ELEM_W-1:0]   elem_q;

    // Read-valid pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_issue;
    end

    // Capture the expected word and location of each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            addr_q <= '0;
            bg_q   <= '0;
            elem_q <= '0;
        end else if (rd_issue) begin
            exp_q  <= exp_word;
            addr_q <= addr;
            bg_q   <= bg_idx;
            elem_q <= elem_idx;
        end
    end

    assign mismatch = rd_q && (rdata != exp_q);

    // First-failure record, cleared by a new launch
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail_seen <= 1'b0;
            fail_addr <= '0;
            fail_bg   <= '0;
            fail_elem <= '0;
        end else if (mismatch && !fail_seen) begin
            fail_seen <= 1'b1;
            fail_addr <= addr_q;
            fail_bg   <= bg_q;
            fail_elem <= elem_q;
        end
    end

endmodule

// File: rtl/mbist_march_engine.sv
// Top: march test engine for a single-port word RAM. Connects the sequencer,
// background generator and comparator. Assumes a RAM with one-cycle read latency.
module mbist_march_engine #(
    parameter  int ADDR_W = 4,
    parameter  int DATA_W = 8,
    localparam int NUM_BG = $clog2(DATA_W) + 1,
    localparam int BG_W   = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         stop_on_fail,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic                         mem_we,
    output logic                         mem_re,
    output logic                         busy,
    output logic                         done,
    output logic                         pass,
    output logic [ADDR_W-1:0]            fail_addr,
    output logic [BG_W-1:0]              fail_bg,
    output logic [mbist_pkg::ELEM_W-1:0] fail_elem
);
    import mbist_pkg::*;

    logic                launch, issue, op_rd, op_inv, mismatch, fail_seen, halt;
    logic [BG_W-1:0]     bg_idx;
    logic [ELEM_W-1:0]   elem_idx;
    logic [DATA_W-1:0]   bg_word, op_word;

    assign halt = mismatch && stop_on_fail;

    mbist_seq #(.ADDR_W(ADDR_W), .NUM_BG(NUM_BG), .BG_W(BG_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .halt     (halt),
        .launch   (launch),
        .issue    (issue),
        .op_rd    (op_rd),
        .op_inv   (op_inv),
        .addr     (mem_addr),
        .bg_idx   (bg_idx),
        .elem_idx (elem_idx),
        .busy     (busy),
        .done     (done)
    );

    mbist_bg_gen #(.DATA_W(DATA_W), .BG_W(BG_W)) u_bg (
        .bg_idx  (bg_idx),
        .pattern (bg_word)
    );

    // Word of the current operation: background or its complement
    assign op_word   = op_inv ? ~bg_word : bg_word;
    assign mem_wdata = op_word;
    assign mem_we    = issue && !op_rd;
    assign mem_re    = issue && op_rd;

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BG_W(BG_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .rd_issue  (mem_re),
        .exp_word  (op_word),
        .addr      (mem_addr),
        .bg_idx    (bg_idx),
        .elem_idx  (elem_idx),
        .rdata     (mem_rdata),
        .mismatch  (mismatch),
        .fail_seen (fail_seen),
        .fail_addr (fail_addr),
        .fail_bg   (fail_bg),
        .fail_elem (fail_elem)
    );

    assign pass = done && !fail_seen;

endmodule

// File: rtl/mbist_march_engine_chk.sv
// Checker: port-level properties of the march test engine, bound to the top.
module mbist_march_engine_chk #(
    parameter  int ADDR_W = 4,
    parameter  int DATA_W = 8,
    localparam int NUM_BG = $clog2(DATA_W) + 1,
    localparam int BG_W   = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [BG_W-1:0]   fail_bg,
    input logic [1:0]        fail_elem
);

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(mem_we || mem_re)) |->
        (mem_addr == $past(mem_addr) || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)
         || mem_addr == ADDR_W'($past(mem_addr) - 1'b1))); // R4

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re)); // R9

    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done) && !$past(start)) |->
        ($stable(fail_addr) && $stable(fail_bg) && $stable(fail_elem))); // R7

endmodule

bind mbist_march_engine mbist_march_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail_addr (fail_addr),
    .fail_bg   (fail_bg),
    .fail_elem (fail_elem)
);

// File: tb/mbist_march_engine_tb.sv
// Bench: RAM model with injectable faults, an operation-stream checker built
// from the algorithm formulas, and directed runs over each fault mode.
module mbist_march_engine_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int N     = 1 << AW;
    localparam int NBG   = 4;
    localparam int TOTAL = NBG * 6 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop_on_fail = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_re, busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic [1:0]    fail_bg;
    logic [1:0]    fail_elem;

    int tests = 0, fails = 0;
    int fault_mode = 0;
    int op_cnt = 0, seq_err = 0, both_err = 0;
    logic [DW-1:0] mem [N];
    logic [AW-1:0] exp_a [TOTAL];
    logic          exp_w [TOTAL];
    logic [DW-1:0] exp_d [TOTAL];

    always #2 clk = ~clk;

    mbist_march_engine #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop_on_fail(stop_on_fail),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done), .pass(pass),
        .fail_addr(fail_addr), .fail_bg(fail_bg), .fail_elem(fail_elem)
    );

    // RAM model: mode 1 bit0 stuck-at-1 at 5, mode 2 bit7 stuck-at-0 at 12,
    // mode 3 bit1 shorted to bit0 on writes at 9
    always @(posedge clk) begin
        if (mem_we) begin
            if (fault_mode == 3 && mem_addr == 4'd9)
                mem[mem_addr] <= {mem_wdata[7:2], mem_wdata[0], mem_wdata[0]};
            else
                mem[mem_addr] <= mem_wdata;
        end
        if (mem_re) begin
            if (fault_mode == 1 && mem_addr == 4'd5)      mem_rdata <= mem[mem_addr] | 8'h01;
            else if (fault_mode == 2 && mem_addr == 4'd12) mem_rdata <= mem[mem_addr] & 8'h7F;
            else                                            mem_rdata <= mem[mem_addr];
        end
    end

    function automatic logic [DW-1:0] bg_word(input int k);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = (k == 0) ? 1'b0 : (((i >> (k - 1)) & 1) == 0);
        return w;
    endfunction

    // Expected operation stream of R2/R3/R4
    task automatic build_stream();
        int p = 0;
        for (int k = 0; k < NBG; k++) begin
            logic [DW-1:0] b = bg_word(k);
            for (int a = 0; a < N; a++) begin
                exp_a[p] = AW'(a); exp_w[p] = 1; exp_d[p] = b; p++;
            end
            for (int a = 0; a < N; a++) begin
                exp_a[p] = AW'(a); exp_w[p] = 0; exp_d[p] = b;  p++;
                exp_a[p] = AW'(a); exp_w[p] = 1; exp_d[p] = ~b; p++;
            end
            for (int a = N - 1; a >= 0; a--) begin
                exp_a[p] = AW'(a); exp_w[p] = 0; exp_d[p] = ~b; p++;
                exp_a[p] = AW'(a); exp_w[p] = 1; exp_d[p] = b;  p++;
                exp_a[p] = AW'(a); exp_w[p] = 0; exp_d[p] = b;  p++;
            end
        end
    endtask

    // Stream monitor: compares each issued operation with the expected stream
    always @(negedge clk) begin
        if (mem_we && mem_re) both_err++;
        if (mem_we || mem_re) begin
            if (op_cnt >= TOTAL) seq_err++;
            else if (mem_addr != exp_a[op_cnt] || mem_we != exp_w[op_cnt] ||
                     (mem_we && mem_wdata != exp_d[op_cnt])) seq_err++;
            op_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One test run; returns the edge count from the start edge to done
    task automatic run(input int fault, input bit sof, input bit mid_start,
                       output int cycles, output int busy_err);
        fault_mode = fault; stop_on_fail = sof;
        @(negedge clk);
        op_cnt = 0; seq_err = 0; both_err = 0; busy_err = 0; cycles = 0;
        start = 1'b1;
        forever begin
            @(posedge clk); cycles++;
            @(negedge clk);
            if (cycles == 1) start = 1'b0;
            if (mid_start && cycles == 100) start = 1'b1;
            if (mid_start && cycles == 101) start = 1'b0;
            if (done) break;
            if (!busy) busy_err++;
            if (cycles > 3 * TOTAL) break;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc, berr;
        for (int a = 0; a < N; a++) mem[a] = '0;
        build_stream();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !pass && !mem_we && !mem_re, "R9 reset state",
              {busy, done, pass, mem_we, mem_re}, 0);
        rst_n = 1'b1;

        // Clean run with a start pulse injected while busy
        run(0, 1'b0, 1'b1, cyc, berr);
        check(seq_err == 0, "R2 R4 operation stream", seq_err, 0);
        check(op_cnt == TOTAL, "R3 operation count", op_cnt, TOTAL);
        check(both_err == 0, "R1 read and write together", both_err, 0);
        check(cyc == TOTAL + 2, "R6 R5 done timing with ignored start", cyc, TOTAL + 2);
        check(berr == 0, "R5 busy held during run", berr, 0);
        check(pass == 1'b1, "R1 R6 clean pass", pass, 1);
        repeat (5) @(negedge clk);
        check(done && pass && !busy, "R6 done held", {done, pass, busy}, 6);

        // Stuck-at-1 at 5, run to end
        run(1, 1'b0, 1'b0, cyc, berr);
        check(op_cnt == TOTAL, "R8 full run without stop", op_cnt, TOTAL);
        check(pass == 1'b0 && done, "R6 fail reported", pass, 0);
        check(fail_addr == 4'd5, "R7 fail address", fail_addr, 5);
        check(fail_bg == 2'd0 && fail_elem == 2'd1, "R7 fail bg/elem",
              {fail_bg, fail_elem}, 1);

        // Same fault with stop at first mismatch
        run(1, 1'b1, 1'b0, cyc, berr);
        check(op_cnt == N + 2 * 5 + 1, "R8 ops before halt", op_cnt, N + 11);
        check(seq_err == 0, "R2 stream prefix before halt", seq_err, 0);
        check(done && !pass && !busy, "R8 halted done without pass", {done, pass, busy}, 4);
        repeat (4) @(negedge clk);
        check(op_cnt == N + 11, "R8 no ops after halt", op_cnt, N + 11);

        // Stuck-at-0 at 12, first seen by descending r1
        run(2, 1'b0, 1'b0, cyc, berr);
        check(fail_addr == 4'd12 && fail_bg == 2'd0 && fail_elem == 2'd2,
              "R7 first failure kept", {fail_addr, fail_bg, fail_elem}, {4'd12, 2'd0, 2'd2});

        // Intra-word short: invisible on solid background
        run(3, 1'b0, 1'b0, cyc, berr);
        check(fail_addr == 4'd9 && fail_bg == 2'd1 && fail_elem == 2'd1,
              "R3 fault found on background 1", {fail_addr, fail_bg, fail_elem},
              {4'd9, 2'd1, 2'd1});

        // Clean run after failures
        run(0, 1'b1, 1'b0, cyc, berr);
        check(pass == 1'b1 && op_cnt == TOTAL, "R10 record cleared by start", pass, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule